// File: doc/BRIEF.md
# Three-Wire Addressed Configuration Port

This block is the configuration slave for a three-loop frequency synthesizer. A host sends words over three wires: a serial clock, a serial data line and an active-low enable. The block samples these pins with the system clock, so the serial clock must run well below the system clock. While the enable is low, each rising edge of the serial clock shifts one data bit into a shift register. When the enable returns high, the most recent 22 bits form a word. The upper 18 bits of that word are data and the lower 4 bits are the address. The data is then stored in the register that the address selects.

The port stores, for each of three loops (RF band 1, RF band 2 and IF), a feedback divider N and a reference divider R. It tracks which RF band is active and gives out a 2-bit phase-detector gain code for each loop. That gain code comes either from a manual gain register or, when automatic gain is enabled, from the loop's N value. Each committed word also produces a one-cycle strobe with its address, so other blocks can see the write. The stream is write-only. There is no ready signal and no back-pressure. The host paces the transfer through the serial clock, and the enable is a plain control pin.

Top module: `tw_cfg_port`

## Requirements
- R1: Bits are sent MSB first. A bit is captured on a rising edge of `sclk` only while `sen_n` is low. On the rising edge of `sen_n`, the last 22 captured bits are committed: bits [21:4] are data and bits [3:0] are the address.
- R2: When more than 22 bits are shifted in before `sen_n` rises, only the last 22 count. The earlier bits have no effect.
- R3: When fewer than 22 bits are shifted in before `sen_n` rises, the word is dropped. There is no strobe and no register changes.
- R4: Each committed word raises `wr_stb` for exactly one clock cycle, with the word's address on `wr_addr`. This happens for every address.
- R5: The divider registers are at these addresses:
  - address 3: RF1 N, data bits [17:0]
  - address 4: RF2 N, bits [16:0]
  - address 5: IF N, bits [15:0]
  - addresses 6, 7 and 8: RF1 R, RF2 R and IF R, bits [12:0] each

  Data bits above each field are ignored. Words sent to other addresses leave all divider registers unchanged.
- R6: `rf_band` is 0 after a write to address 3 or 6, and 1 after a write to address 4 or 7. Other writes leave it unchanged.
- R7: Address 0 bit 2 is the automatic gain enable. Address 1 holds the manual gain codes: bits [1:0] for RF1, [3:2] for RF2 and [5:4] for IF. When automatic gain is off, each gain output equals its manual code.
- R8: When automatic gain is on, each loop's gain code follows from its N value: 00 for N ≤ 4095, 01 for 4096–16383, 10 for 16384–32767, and 11 for N ≥ 32768.
- R9: A write to a loop's R register sets that loop's bit in `r_err` if the new R is below the minimum or above 8189. The minimum depends on the loop's gain code at the time of the write: 7 for code 00, 8 for 01, 10 for 10 and 14 for 11. In `r_err`, bit 0 is RF1, bit 1 is RF2 and bit 2 is IF. A set bit stays set until reset.
- R10: After reset, all registers and `r_err` are zero, `rf_band` is 0, and `wr_stb` is low.
- R11: Edges on `sclk` while `sen_n` is high are ignored, and a high `sen_n` clears the received bit count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| sdata | input | 1 | Serial data, MSB first |
| sen_n | input | 1 | Active-low serial enable; its rising edge commits the word |
| n_rf1 | output | 18 | RF band 1 feedback divider |
| n_rf2 | output | 17 | RF band 2 feedback divider |
| n_if | output | 16 | IF feedback divider |
| r_rf1 | output | 13 | RF band 1 reference divider |
| r_rf2 | output | 13 | RF band 2 reference divider |
| r_if | output | 13 | IF reference divider |
| rf_band | output | 1 | Active RF band: 0 is band 1, 1 is band 2 |
| gain_rf1 | output | 2 | Effective gain code, RF band 1 |
| gain_rf2 | output | 2 | Effective gain code, RF band 2 |
| gain_if | output | 2 | Effective gain code, IF |
| r_err | output | 3 | Sticky R range errors, one bit per loop |
| wr_stb | output | 1 | One-cycle strobe for each committed word |
| wr_addr | output | 4 | Address of the committed word |

## Verification
The R range check and the gain lookup act in the same cycle. An R word is judged against the gain code the loop has at the moment it commits, and that code depends on an N value or an enable bit that the previous word may have just changed. The bench provokes this in two ways. It sends an N word and an R word back to back with automatic gain on, so that N moves the gain code across a boundary and the R minimum changes with it. It also toggles the enable between R writes. A reference model advances in word order and says whether each R should set its error bit. Random words with extra leading bits, short frames mixed in, and random addresses also cover the overlap of band selection with R and N writes.

// File: rtl/tw_cfg_pkg.sv
package tw_cfg_pkg;
  localparam int CP_DATA_W   = 18;
  localparam int CP_ADDR_W   = 4;
  localparam int CP_R_W      = 13;
  localparam int CP_LOOPS    = 3;
  localparam int CP_N_BASE   = 3;
  localparam int CP_R_BASE   = 6;
  localparam int CP_CFG_ADDR = 0;
  localparam int CP_GAIN_ADDR = 1;
  localparam int CP_AUTO_BIT = 2;
  localparam int CP_R_MAX    = 8189;
  localparam int CP_GAIN_W   = 2;

  // N field width shrinks by one bit per loop: 18, 17, 16
  function automatic int n_width(int idx);
    return CP_DATA_W - idx;
  endfunction

  function automatic int n_offset(int idx);
    int acc;
    acc = 0;
    for (int k = 0; k < idx; k++) acc += n_width(k);
    return acc;
  endfunction

  localparam int CP_NFLAT_W = n_offset(CP_LOOPS);
  localparam int CP_RFLAT_W = CP_LOOPS * CP_R_W;
  localparam int CP_GFLAT_W = CP_LOOPS * CP_GAIN_W;

  function automatic logic [CP_GAIN_W-1:0] gain_of_n(logic [CP_DATA_W-1:0] nval);
    if (nval < CP_DATA_W'(4096))       return 2'b00;
    else if (nval < CP_DATA_W'(16384)) return 2'b01;
    else if (nval < CP_DATA_W'(32768)) return 2'b10;
    else                               return 2'b11;
  endfunction

  function automatic logic [CP_R_W-1:0] r_floor(logic [CP_GAIN_W-1:0] g);
    case (g)
      2'b00:   return CP_R_W'(7);
      2'b01:   return CP_R_W'(8);
      2'b10:   return CP_R_W'(10);
      default: return CP_R_W'(14);
    endcase
  endfunction
endpackage

// File: rtl/tw_serial_rx.sv
module tw_serial_rx
  import tw_cfg_pkg::*;
#(
  parameter int DATA_W = CP_DATA_W,
  parameter int ADDR_W = CP_ADDR_W,
  parameter int SYNC_N = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              sdata,
  input  logic              sen_n,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam int WORD_W = DATA_W + ADDR_W;
  localparam int CNT_W  = $clog2(WORD_W + 1);

  logic [SYNC_N-1:0] sclk_q, sdata_q, senn_q;
  logic              sclk_d, senn_d;
  logic              sclk_s, sdata_s, senn_s;
  logic              sclk_rise, sen_rise;
  logic [WORD_W-1:0] shreg;
  logic [CNT_W-1:0]  bit_cnt;
  logic              full_word;

  // pin synchronizers; enable resets to its idle (high) level
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= '0;
      sdata_q <= '0;
      senn_q  <= '1;
      sclk_d  <= 1'b0;
      senn_d  <= 1'b1;
    end else begin
      sclk_q  <= {sclk_q[SYNC_N-2:0], sclk};
      sdata_q <= {sdata_q[SYNC_N-2:0], sdata};
      senn_q  <= {senn_q[SYNC_N-2:0], sen_n};
      sclk_d  <= sclk_s;
      senn_d  <= senn_s;
    end
  end

  assign sclk_s    = sclk_q[SYNC_N-1];
  assign sdata_s   = sdata_q[SYNC_N-1];
  assign senn_s    = senn_q[SYNC_N-1];
  assign sclk_rise = sclk_s & ~sclk_d & ~senn_s;
  assign sen_rise  = senn_s & ~senn_d;
  assign full_word = (bit_cnt == CNT_W'(WORD_W));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else begin
      if (sclk_rise) shreg <= {shreg[WORD_W-2:0], sdata_s};
      if (senn_s) bit_cnt <= '0;
      else if (sclk_rise && !full_word) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_stb <= sen_rise && full_word;
      if (sen_rise && full_word) begin
        wr_addr <= shreg[ADDR_W-1:0];
        wr_data <= shreg[WORD_W-1:ADDR_W];
      end
    end
  end

  // R4: strobe lasts one cycle
  a_r4_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
  // R3: a commit only follows a complete word
  a_r3_full_before_commit: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(bit_cnt) == CNT_W'(WORD_W));
  // R11: count is cleared while the enable is high
  a_r11_count_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    $past(senn_s) |-> bit_cnt == '0);
endmodule

// File: rtl/tw_reg_bank.sv
module tw_reg_bank
  import tw_cfg_pkg::*;
#(
  parameter int DATA_W = CP_DATA_W,
  parameter int ADDR_W = CP_ADDR_W,
  parameter int R_W    = CP_R_W,
  parameter int LOOPS  = CP_LOOPS
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [DATA_W-1:0]        wr_data,
  output logic [CP_NFLAT_W-1:0]    n_flat,
  output logic [LOOPS*R_W-1:0]     r_flat,
  output logic [LOOPS-1:0]         r_we,
  output logic [R_W-1:0]           r_wdata,
  output logic                     auto_gain,
  output logic [LOOPS*CP_GAIN_W-1:0] man_gain,
  output logic                     rf_band
);
  localparam int GW = LOOPS * CP_GAIN_W;

  logic sel_band1, sel_band2;

  assign r_wdata = wr_data[R_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      auto_gain <= 1'b0;
      man_gain  <= '0;
    end else if (wr_stb) begin
      if (wr_addr == ADDR_W'(CP_CFG_ADDR))  auto_gain <= wr_data[CP_AUTO_BIT];
      if (wr_addr == ADDR_W'(CP_GAIN_ADDR)) man_gain  <= wr_data[GW-1:0];
    end
  end

  for (genvar g = 0; g < LOOPS; g++) begin : g_loop
    localparam int NW  = n_width(g);
    localparam int OFF = n_offset(g);
    logic [NW-1:0]  n_r;
    logic [R_W-1:0] r_r;
    logic           n_hit;

    assign n_hit   = wr_stb && (wr_addr == ADDR_W'(CP_N_BASE + g));
    assign r_we[g] = wr_stb && (wr_addr == ADDR_W'(CP_R_BASE + g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        n_r <= '0;
        r_r <= '0;
      end else begin
        if (n_hit)   n_r <= wr_data[NW-1:0];
        if (r_we[g]) r_r <= wr_data[R_W-1:0];
      end
    end

    assign n_flat[OFF +: NW]    = n_r;
    assign r_flat[g*R_W +: R_W] = r_r;
  end

  assign sel_band1 = wr_stb && (wr_addr == ADDR_W'(CP_N_BASE) ||
                                wr_addr == ADDR_W'(CP_R_BASE));
  assign sel_band2 = wr_stb && (wr_addr == ADDR_W'(CP_N_BASE + 1) ||
                                wr_addr == ADDR_W'(CP_R_BASE + 1));

  // most recent band-1 or band-2 divider write wins
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rf_band <= 1'b0;
    else if (sel_band2) rf_band <= 1'b1;
    else if (sel_band1) rf_band <= 1'b0;
  end

  a_r6_band_follows_rf2: assert property (@(posedge clk) disable iff (!rst_n)
    sel_band2 |=> rf_band);
  a_r6_band_follows_rf1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_band1 |=> !rf_band);
  a_r5_r_holds_without_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(r_flat) && $stable(n_flat));
  a_r5_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(r_we));
endmodule

// File: rtl/tw_loop_gain_chk.sv
module tw_loop_gain_chk
  import tw_cfg_pkg::*;
#(
  parameter int N_W   = CP_DATA_W,
  parameter int R_W   = CP_R_W,
  parameter int R_MAX = CP_R_MAX
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 auto_gain,
  input  logic [CP_GAIN_W-1:0] man_gain,
  input  logic [N_W-1:0]       n_val,
  input  logic                 r_we,
  input  logic [R_W-1:0]       r_wdata,
  output logic [CP_GAIN_W-1:0] gain,
  output logic                 r_err
);
  logic [R_W-1:0] r_min;
  logic           r_bad;

  assign gain  = auto_gain ? gain_of_n(CP_DATA_W'(n_val)) : man_gain;
  assign r_min = r_floor(gain);
  assign r_bad = (r_wdata < r_min) || (r_wdata > R_W'(R_MAX));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               r_err <= 1'b0;
    else if (r_we && r_bad)   r_err <= 1'b1;
  end

  a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    r_err |=> r_err);
  a_r9_err_only_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(r_err) |-> $past(r_we));
  a_r8_top_code: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_gain && n_val >= N_W'(32768)) |-> gain == 2'b11);
  a_r7_manual_pass: assert property (@(posedge clk) disable iff (!rst_n)
    !auto_gain |-> gain == man_gain);
endmodule

// File: rtl/tw_cfg_port.sv
module tw_cfg_port
  import tw_cfg_pkg::*;
#(
  parameter int SYNC_N = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sclk,
  input  logic                 sdata,
  input  logic                 sen_n,
  output logic [17:0]          n_rf1,
  output logic [16:0]          n_rf2,
  output logic [15:0]          n_if,
  output logic [CP_R_W-1:0]    r_rf1,
  output logic [CP_R_W-1:0]    r_rf2,
  output logic [CP_R_W-1:0]    r_if,
  output logic                 rf_band,
  output logic [CP_GAIN_W-1:0] gain_rf1,
  output logic [CP_GAIN_W-1:0] gain_rf2,
  output logic [CP_GAIN_W-1:0] gain_if,
  output logic [CP_LOOPS-1:0]  r_err,
  output logic                 wr_stb,
  output logic [CP_ADDR_W-1:0] wr_addr
);
  logic [CP_DATA_W-1:0]  wr_data;
  logic [CP_NFLAT_W-1:0] n_flat;
  logic [CP_RFLAT_W-1:0] r_flat;
  logic [CP_LOOPS-1:0]   r_we;
  logic [CP_R_W-1:0]     r_wdata;
  logic                  auto_gain;
  logic [CP_GFLAT_W-1:0] man_gain;
  logic [CP_GFLAT_W-1:0] gain_flat;

  tw_serial_rx #(
    .DATA_W(CP_DATA_W), .ADDR_W(CP_ADDR_W), .SYNC_N(SYNC_N)
  ) u_rx (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sen_n(sen_n),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  tw_reg_bank #(
    .DATA_W(CP_DATA_W), .ADDR_W(CP_ADDR_W), .R_W(CP_R_W), .LOOPS(CP_LOOPS)
  ) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_addr(wr_addr),
    .wr_data(wr_data), .n_flat(n_flat), .r_flat(r_flat), .r_we(r_we),
    .r_wdata(r_wdata), .auto_gain(auto_gain), .man_gain(man_gain),
    .rf_band(rf_band)
  );

  for (genvar g = 0; g < CP_LOOPS; g++) begin : g_chk
    localparam int NW  = n_width(g);
    localparam int OFF = n_offset(g);
    tw_loop_gain_chk #(
      .N_W(NW), .R_W(CP_R_W), .R_MAX(CP_R_MAX)
    ) u_chk (
      .clk(clk), .rst_n(rst_n), .auto_gain(auto_gain),
      .man_gain(man_gain[g*CP_GAIN_W +: CP_GAIN_W]),
      .n_val(n_flat[OFF +: NW]), .r_we(r_we[g]), .r_wdata(r_wdata),
      .gain(gain_flat[g*CP_GAIN_W +: CP_GAIN_W]), .r_err(r_err[g])
    );
  end

  assign n_rf1    = n_flat[n_offset(0) +: n_width(0)];
  assign n_rf2    = n_flat[n_offset(1) +: n_width(1)];
  assign n_if     = n_flat[n_offset(2) +: n_width(2)];
  assign r_rf1    = r_flat[0*CP_R_W +: CP_R_W];
  assign r_rf2    = r_flat[1*CP_R_W +: CP_R_W];
  assign r_if     = r_flat[2*CP_R_W +: CP_R_W];
  assign gain_rf1 = gain_flat[1:0];
  assign gain_rf2 = gain_flat[3:2];
  assign gain_if  = gain_flat[5:4];

  a_r10_idle_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_stb) |-> $past(sen_n) || $past(sen_n, 2) || $past(sen_n, 3));
endmodule

// File: tb/tw_cfg_port_tb_top.sv
module tw_cfg_port_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, sdata = 1'b0, sen_n = 1'b1;
  logic [17:0] n_rf1;
  logic [16:0] n_rf2;
  logic [15:0] n_if;
  logic [12:0] r_rf1, r_rf2, r_if;
  logic rf_band, wr_stb;
  logic [1:0] gain_rf1, gain_rf2, gain_if;
  logic [2:0] r_err;
  logic [3:0] wr_addr;

  int checks = 0, failures = 0;
  int stb_cnt = 0, stb_double = 0;
  logic [3:0] stb_last = '0;
  logic stb_prev = 1'b0;
  bit done = 0;

  // reference model state
  logic [17:0] m_n [3];
  logic [12:0] m_r [3];
  logic m_auto, m_band;
  logic [5:0] m_man;
  logic [2:0] m_err;
  int m_stb;
  logic [3:0] m_last;

  always #5 clk = ~clk;

  tw_cfg_port dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata), .sen_n(sen_n),
    .n_rf1(n_rf1), .n_rf2(n_rf2), .n_if(n_if), .r_rf1(r_rf1), .r_rf2(r_rf2),
    .r_if(r_if), .rf_band(rf_band), .gain_rf1(gain_rf1), .gain_rf2(gain_rf2),
    .gain_if(gain_if), .r_err(r_err), .wr_stb(wr_stb), .wr_addr(wr_addr)
  );

  always @(posedge clk) begin
    if (wr_stb) begin
      stb_cnt  <= stb_cnt + 1;
      stb_last <= wr_addr;
      if (stb_prev) stb_double <= stb_double + 1;
    end
    stb_prev <= wr_stb;
  end

  function automatic logic [1:0] exp_gain_of(logic [17:0] n);
    if (n <= 18'd4095) return 2'b00;
    if (n <= 18'd16383) return 2'b01;
    if (n <= 18'd32767) return 2'b10;
    return 2'b11;
  endfunction

  function automatic int exp_rmin(logic [1:0] g);
    case (g) 2'b00: return 7; 2'b01: return 8; 2'b10: return 10; default: return 14; endcase
  endfunction

  function automatic logic [1:0] eff_gain(int i);
    return m_auto ? exp_gain_of(m_n[i]) : m_man[2*i +: 2];
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 3; i++) begin m_n[i] = '0; m_r[i] = '0; end
    m_auto = 0; m_band = 0; m_man = '0; m_err = '0; m_stb = 0; m_last = '0;
  endtask

  task automatic model_commit(logic [31:0] v, int nbits);
    logic [17:0] d;
    logic [3:0] a;
    if (nbits < 22) return;
    d = v[21:4]; a = v[3:0];
    m_stb++; m_last = a;
    case (a)
      4'd0: m_auto = d[2];
      4'd1: m_man = d[5:0];
      4'd3: begin m_n[0] = d; m_band = 0; end
      4'd4: begin m_n[1] = {1'b0, d[16:0]}; m_band = 1; end
      4'd5: m_n[2] = {2'b0, d[15:0]};
      4'd6, 4'd7, 4'd8: begin
        int i;
        i = int'(a) - 6;
        if (int'(d[12:0]) < exp_rmin(eff_gain(i)) || d[12:0] > 13'd8189) m_err[i] = 1'b1;
        m_r[i] = d[12:0];
        if (i == 0) m_band = 0;
        if (i == 1) m_band = 1;
      end
      default: ;
    endcase
  endtask

  task automatic send(logic [31:0] v, int nbits);
    sen_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = nbits - 1; i >= 0; i--) begin
      sdata = v[i];
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (4) @(negedge clk);
    sen_n = 1'b1;
    repeat (10) @(negedge clk);
    model_commit(v, nbits);
  endtask

  task automatic check_all(string req);
    chk(n_rf1 == m_n[0], {req, "/R5 n_rf1"}, n_rf1, m_n[0]);
    chk(n_rf2 == m_n[1][16:0], {req, "/R5 n_rf2"}, n_rf2, m_n[1]);
    chk(n_if == m_n[2][15:0], {req, "/R5 n_if"}, n_if, m_n[2]);
    chk(r_rf1 == m_r[0], {req, "/R5 r_rf1"}, r_rf1, m_r[0]);
    chk(r_rf2 == m_r[1], {req, "/R5 r_rf2"}, r_rf2, m_r[1]);
    chk(r_if == m_r[2], {req, "/R5 r_if"}, r_if, m_r[2]);
    chk(rf_band == m_band, {req, "/R6 band"}, rf_band, m_band);
    chk(gain_rf1 == eff_gain(0), {req, "/R7R8 gain_rf1"}, gain_rf1, eff_gain(0));
    chk(gain_rf2 == eff_gain(1), {req, "/R7R8 gain_rf2"}, gain_rf2, eff_gain(1));
    chk(gain_if == eff_gain(2), {req, "/R7R8 gain_if"}, gain_if, eff_gain(2));
    chk(r_err == m_err, {req, "/R9 r_err"}, r_err, m_err);
    chk(stb_cnt == m_stb, {req, "/R4 strobe count"}, stb_cnt, m_stb);
    chk(stb_last == m_last, {req, "/R4 strobe addr"}, stb_last, m_last);
    chk(stb_double == 0, {req, "/R4 strobe width"}, stb_double, 0);
  endtask

  function automatic logic [31:0] word(logic [17:0] d, logic [3:0] a);
    return {10'd0, d, a};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int nb;
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_all("R10");
    chk(wr_stb == 1'b0, "R10 wr_stb idle", wr_stb, 0);

    // R1: basic N write for band 2, then R1 band word
    send(word(18'h1ABCD, 4'd4), 22); check_all("R1");
    send(word(18'd100, 4'd6), 22);   check_all("R1 R6");
    // R5: upper bits ignored in IF N and R fields
    send(word(18'h3FFFF, 4'd5), 22); check_all("R5 if mask");
    send(word(18'h3E00A, 4'd8), 22); check_all("R5 r mask");
    // R5: unmapped addresses leave dividers
    send(word(18'h3FFFF, 4'd2), 22); check_all("R5 unmapped2");
    send(word(18'h12345, 4'd15), 22); check_all("R5 unmapped15");
    // R2: extra leading bits
    send({7'h55, 1'b1, 6'h00, 18'h00777, 4'd3} & 32'h3FFFFFFF, 30); check_all("R2");
    // R3: short frame dropped
    send(word(18'h00123, 4'd7), 21); check_all("R3 short");
    send(32'h5, 6); check_all("R3 tiny");
    // R11: clock edges with enable high
    for (int k = 0; k < 5; k++) begin
      sdata = 1'b1; repeat (4) @(negedge clk); sclk = 1'b1;
      repeat (4) @(negedge clk); sclk = 1'b0;
    end
    send(word(18'd9, 4'd7), 22); check_all("R11");
    // R7: manual gains with auto off
    send(word(18'b11_10_01, 4'd1), 22); check_all("R7 manual");
    // R9 with manual gain 11 on IF: 13 illegal, 14 legal
    send(word(18'd14, 4'd8), 22); check_all("R9 at floor");
    send(word(18'd13, 4'd8), 22); check_all("R9 below floor");
    // R8: auto gain boundaries on RF1 N
    send(word(18'd4, 4'd0), 22); check_all("R8 auto on");
    begin
      int bnd [8] = '{4095, 4096, 16383, 16384, 32767, 32768, 0, 262143};
      for (int k = 0; k < 8; k++) begin
        send(word(18'(bnd[k]), 4'd3), 22); check_all("R8 boundary");
      end
    end
    // R9 same-cycle overlap: N moves gain, then R judged against new floor
    send(word(18'd4095, 4'd4), 22);
    send(word(18'd7, 4'd7), 22); check_all("R9 rf2 legal at 00");
    send(word(18'd16384, 4'd4), 22);
    send(word(18'd9, 4'd7), 22); check_all("R9 rf2 below 10");
    send(word(18'd8189, 4'd6), 22); check_all("R9 rf1 max legal");
    send(word(18'd8190, 4'd6), 22); check_all("R9 rf1 over max");

    // constrained random mix
    for (int k = 0; k < 50; k++) begin
      logic [17:0] d;
      logic [3:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      a = 4'($urandom_range(0, 9));
      d = 18'($urandom());
      if (sel < 3) d = 18'($urandom_range(0, 20));
      v = {10'($urandom()), d, a};
      if (sel == 9) nb = $urandom_range(8, 21);
      else nb = $urandom_range(22, 32);
      if (nb < 32) v = v & ((32'd1 << nb) - 1);
      send(v, nb);
      check_all("R1 R2 R3 random");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule